// File: doc/BRIEF.md
# Output Compare Unit With Master Override Channel

This block is an eight-channel output-compare timer. All channels watch one shared free-running 16-bit counter. Each channel has its own compare register, a mode bit and a 2-bit action code. When a channel is in compare mode and the counter equals its compare value, the action code toggles, clears or sets that channel's pin, or leaves it alone.

The highest channel is a master. When it matches, it can force a preset level onto any compare-mode channel whose bit is set in an override mask. That level comes from an override data register. When the master match and a channel's own match fall on the same count, the master level is loaded first. The channel's own action is then applied to that level.

Software loads every setting through a plain address/data/write-strobe port. A counter-enable input gates both the counting and the matching. Each pin output is registered. It has an enable that is high while its channel is in compare mode.

Top module: `oc_master_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, every pin and every pin enable reads 0, and the counter restarts from 0.
- R2: The counter advances by one on each clock with the count enable high, wraps from 0xFFFF to 0x0000, and holds otherwise. Each count value is tested for a match only on the one enabled cycle the counter spends on it.
- R3: On a channel match, the action code changes the pin at the next clock edge: 0 leaves it unchanged, 1 inverts it, 2 drives 0, 3 drives 1.
- R4: A channel whose mode bit is 0 never changes its pin and has its pin enable low. A channel whose mode bit is 1 has its pin enable high.
- R5: For a non-master channel x with override mask bit x set and both channels in compare mode, a master match without an own match sets pin x to override data bit x.
- R6: With master mask bit 7 clear, a master match applies the master's own action code to pin 7. With master mask bit 7 set, it loads override data bit 7 into pin 7 and the code is ignored.
- R7: When channel x (mask bit set) and the master match on the same count, pin x becomes the master data bit with channel x's action applied to it. For example, toggle gives the inverted data bit, and code 0 gives the data bit itself.
- R8: A channel with its mask bit clear is unaffected by master matches. Its own match applies only its own action.
- R9: Register writes take effect from the following clock. Addresses 0..7 hold compare values. Address 8 holds the mode bits. Address 9 holds the action codes, with channel i at bits [2i+1:2i]. Address 10 holds the override mask. Address 11 holds the override data.
- R10: A compare value of 0 matches when the counter holds 0, including right after it wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; gates counting and matching |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pin_o | output | 8 | Channel pin levels |
| pin_oe | output | 8 | Channel pin enables |

## Verification
Some properties are checked on every cycle by assertions:
- the counter steps and holds,
- a disabled channel's pin stays frozen,
- forced, set and clear outcomes on a match,
- the inverted-data result of a coincident toggle,
- the one-clock latency of a mask write.

Other behaviours only appear over whole scenarios, and the bench compares every pin against a reference model on each clock to show them:
- a match at count 0 after a full wrap;
- a compare write that lands on the count it names;
- the combined outcomes of random masks, data and codes with forced coincident master matches.

// File: rtl/ocm_pkg.sv
package ocm_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_INVERT = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } act_e;

  function automatic logic act_apply(input logic [1:0] code, input logic cur);
    case (act_e'(code))
      ACT_INVERT: return ~cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/ocm_counter.sv
module ocm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R2: hold and step
  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q));
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt_q == CW'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/ocm_regs.sv
module ocm_regs #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 4,
  parameter int DW  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  output logic [NCH-1:0][CW-1:0] cmp,
  output logic [NCH-1:0]      sel,
  output logic [2*NCH-1:0]    act,
  output logic [NCH-1:0]      mask,
  output logic [NCH-1:0]      data
);
  localparam int A_SEL  = NCH;
  localparam int A_ACT  = NCH + 1;
  localparam int A_MASK = NCH + 2;
  localparam int A_DATA = NCH + 3;

  logic [NCH-1:0][CW-1:0] cmp_q;
  logic [NCH-1:0]         sel_q, mask_q, data_q;
  logic [2*NCH-1:0]       act_q;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst)
          cmp_q[g] <= '0;
        else if (wr_en && wr_addr == AW'(g))
          cmp_q[g] <= wr_data[CW-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      act_q  <= '0;
      mask_q <= '0;
      data_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_SEL))  sel_q  <= wr_data[NCH-1:0];
      if (wr_addr == AW'(A_ACT))  act_q  <= wr_data[2*NCH-1:0];
      if (wr_addr == AW'(A_MASK)) mask_q <= wr_data[NCH-1:0];
      if (wr_addr == AW'(A_DATA)) data_q <= wr_data[NCH-1:0];
    end
  end

  assign cmp  = cmp_q;
  assign sel  = sel_q;
  assign act  = act_q;
  assign mask = mask_q;
  assign data = data_q;

  // R9: a mask write is visible one clock later
  a_r9_mask_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(A_MASK)) |=> mask_q == $past(wr_data[NCH-1:0]));
endmodule

// File: rtl/ocm_match.sv
module ocm_match #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic [CW-1:0]          cnt,
  input  logic                   en,
  input  logic [NCH-1:0][CW-1:0] cmp,
  input  logic [NCH-1:0]         sel,
  output logic [NCH-1:0]         hit
);
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_cmp
      assign hit[g] = en && sel[g] && (cnt == cmp[g]);
    end
  endgenerate
endmodule

// File: rtl/ocm_channel.sv
module ocm_channel #(
  parameter bit IS_MASTER = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       own_hit,
  input  logic       master_hit,
  input  logic       mask_bit,
  input  logic       data_bit,
  input  logic [1:0] act,
  output logic       pin
);
  import ocm_pkg::*;

  logic pin_q, force_lvl, own_fire, base, nxt;

  generate
    if (IS_MASTER) begin : g_master
      assign force_lvl = master_hit && mask_bit;
      assign own_fire  = own_hit && !mask_bit;
    end else begin : g_slave
      assign force_lvl = master_hit && sel && mask_bit;
      assign own_fire  = own_hit;
    end
  endgenerate

  always_comb begin
    base = force_lvl ? data_bit : pin_q;
    nxt  = own_fire ? act_apply(act, base) : base;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= nxt;
  end

  assign pin = pin_q;

  // R4: channel out of compare mode keeps its pin
  a_r4_idle_frozen: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(pin_q));
  // R3: set and clear codes
  a_r3_set_high: assert property (@(posedge clk) disable iff (rst)
    (own_fire && act == 2'd3) |=> pin_q);
  a_r3_set_low: assert property (@(posedge clk) disable iff (rst)
    (own_fire && act == 2'd2) |=> !pin_q);
  // R5: forced level without own action
  a_r5_forced: assert property (@(posedge clk) disable iff (rst)
    (force_lvl && !own_fire) |=> pin_q == $past(data_bit));
  // R7: coincident toggle inverts the forced level
  a_r7_coinc_toggle: assert property (@(posedge clk) disable iff (rst)
    (force_lvl && own_fire && act == 2'd1) |=> pin_q == !$past(data_bit));
endmodule

// File: rtl/oc_master_unit.sv
module oc_master_unit #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = $clog2(NCH + 4),
  parameter int DW  = (CW > 2*NCH) ? CW : 2*NCH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cnt_en,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pin_o,
  output logic [NCH-1:0] pin_oe
);
  localparam int MST = NCH - 1;

  logic [CW-1:0]          cnt;
  logic [NCH-1:0][CW-1:0] cmp;
  logic [NCH-1:0]         sel, mask, data, hit;
  logic [2*NCH-1:0]       act;

  ocm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .cnt(cnt)
  );

  ocm_regs #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp(cmp), .sel(sel), .act(act), .mask(mask), .data(data)
  );

  ocm_match #(.NCH(NCH), .CW(CW)) u_match (
    .cnt(cnt), .en(cnt_en), .cmp(cmp), .sel(sel), .hit(hit)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      ocm_channel #(.IS_MASTER(g == MST)) u_ch (
        .clk(clk), .rst(rst), .sel(sel[g]), .own_hit(hit[g]),
        .master_hit(hit[MST]), .mask_bit(mask[g]), .data_bit(data[g]),
        .act(act[2*g +: 2]), .pin(pin_o[g])
      );
    end
  endgenerate

  assign pin_oe = sel;

  // R8: unmasked channel without own match ignores the master
  a_r8_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
    (!mask[0] && !hit[0]) |=> $stable(pin_o[0]));
  // R6: master with mask bit set takes its data bit
  a_r6_master_forced: assert property (@(posedge clk) disable iff (rst)
    (hit[MST] && mask[MST]) |=> pin_o[MST] == $past(data[MST]));
endmodule

// File: tb/sim_oc_master_unit.sv
module sim_oc_master_unit;
  logic clk = 1'b0, rst = 1'b1, cnt_en = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0] pin_o, pin_oe;

  oc_master_unit u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  string tag = "R1";
  bit en_b = 1'b0;

  bit [15:0] m_cmp [8];
  bit [1:0]  m_act [8];
  bit [7:0]  m_sel, m_mask, m_data, m_pin;
  int        m_cnt;

  function automatic bit do_act(bit [1:0] c, bit v);
    if (c == 2'd1) return !v;
    if (c == 2'd2) return 1'b0;
    if (c == 2'd3) return 1'b1;
    return v;
  endfunction

  task automatic model_step(bit r, bit e, bit w, int a, int d);
    bit m7;
    bit [7:0] np;
    if (r) begin
      foreach (m_cmp[i]) begin m_cmp[i] = 0; m_act[i] = 0; end
      m_sel = 0; m_mask = 0; m_data = 0; m_pin = 0; m_cnt = 0;
      return;
    end
    m7 = e && m_sel[7] && (m_cnt == int'(m_cmp[7]));
    np = m_pin;
    for (int i = 0; i < 7; i++) begin
      bit own = e && m_sel[i] && (m_cnt == int'(m_cmp[i]));
      if (m7 && m_sel[i] && m_mask[i]) np[i] = m_data[i];
      if (own) np[i] = do_act(m_act[i], np[i]);
    end
    if (m7) np[7] = m_mask[7] ? m_data[7] : do_act(m_act[7], m_pin[7]);
    m_pin = np;
    if (w) begin
      if (a < 8) m_cmp[a] = d[15:0];
      else if (a == 8)  m_sel = d[7:0];
      else if (a == 9)  for (int i = 0; i < 8; i++) m_act[i] = d[2*i +: 2];
      else if (a == 10) m_mask = d[7:0];
      else if (a == 11) m_data = d[7:0];
    end
    if (e) m_cnt = (m_cnt + 1) % 65536;
  endtask

  task automatic cyc(bit w, int a, int d);
    bit r = rst;
    bit e = en_b;
    wr_en = w; wr_addr = a[3:0]; wr_data = d[15:0]; cnt_en = e;
    @(posedge clk);
    model_step(r, e, w, a, d);
    #2;
    checks++;
    if (pin_o !== m_pin || pin_oe !== m_sel) begin
      errors++;
      $display("FAIL %s pin=%h oe=%h expected pin=%h oe=%h", tag, pin_o, pin_oe, m_pin, m_sel);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1; en_b = 1'b0;
    tag = "R1";
    cyc(1'b0, 0, 0); cyc(1'b0, 0, 0);
    rst = 1'b0;
    cyc(1'b0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9 and R4: mode bits reach pin enables one clock after the write
    tag = "R9";
    cyc(1'b1, 8, 16'h000F);
    cyc(1'b1, 9, 16'h00E4);            // ch0 keep, ch1 invert, ch2 low, ch3 high
    cyc(1'b1, 0, 5); cyc(1'b1, 1, 6); cyc(1'b1, 2, 7); cyc(1'b1, 3, 8);
    // R4: channel 5 not in compare mode, code high, compare 9
    tag = "R4";
    cyc(1'b1, 5, 9);
    cyc(1'b1, 9, 16'h0CE4);
    // R3: run across the matches (counter restarts from 0)
    tag = "R3";
    en_b = 1'b1; idle(20);
    // R2: hold the counter, then resume
    tag = "R2";
    en_b = 1'b0; idle(6);
    cyc(1'b1, 1, 30);
    en_b = 1'b1; idle(15);

    // R5 R6 R8: master toggles pin 7, forces masked channels
    do_reset();
    tag = "R5";
    cyc(1'b1, 8, 16'h00FF);
    cyc(1'b1, 11, 16'h00A5);
    cyc(1'b1, 10, 16'h000F);
    cyc(1'b1, 7, 10);
    cyc(1'b1, 9, 16'h4000);           // master invert
    cyc(1'b1, 0, 20); cyc(1'b1, 4, 4);
    en_b = 1'b1; idle(30);
    tag = "R6";
    en_b = 1'b0;
    cyc(1'b1, 10, 16'h0080);
    cyc(1'b1, 11, 16'h0080);
    tag = "R8";
    en_b = 1'b1; idle(30);

    // R7: coincident master and local matches with every code
    do_reset();
    tag = "R7";
    cyc(1'b1, 8, 16'h00FF);
    cyc(1'b1, 10, 16'h000F);
    cyc(1'b1, 11, 16'h0005);
    cyc(1'b1, 9, 16'h00E4);
    for (int i = 0; i < 4; i++) cyc(1'b1, i, 12);
    cyc(1'b1, 7, 12);
    en_b = 1'b1; idle(20);

    // R9: compare written to the value the counter holds that cycle
    tag = "R9";
    cyc(1'b1, 9, 16'h0001);
    cyc(1'b1, 0, m_cnt);
    idle(5);

    // R10: compare of zero matches after a full wrap
    do_reset();
    tag = "R10";
    cyc(1'b1, 8, 16'h0003);
    cyc(1'b1, 9, 16'h000D);           // ch0 invert, ch1 high
    cyc(1'b1, 1, 16'hFFFF);
    en_b = 1'b1; idle(65545);

    // R5 R7 R8: random programs with forced coincident matches
    for (int r = 0; r < 40; r++) begin
      int j;
      do_reset();
      tag = "R5 R7 R8 random";
      for (int i = 0; i < 8; i++) cyc(1'b1, i, $urandom_range(0, 40));
      j = $urandom_range(0, 6);
      cyc(1'b1, j, m_cmp[7]);
      cyc(1'b1, 8, $urandom_range(0, 255) | 128);
      cyc(1'b1, 9, $urandom_range(0, 65535));
      cyc(1'b1, 10, $urandom_range(0, 255));
      cyc(1'b1, 11, $urandom_range(0, 255));
      en_b = 1'b1; idle(50);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule